// File: doc/BRIEF.md
# Wait and Stop Low-Power Sequencer

This block sits beside the CPU and decides when its clocks run. A decoded WAIT strobe gates the CPU clock and leaves the peripheral clock running. A decoded STOP strobe gates both clocks. Either strobe also gives a one-cycle pulse that tells the CPU to clear its interrupt mask, so that a pending interrupt can wake the part.

A wakeup event brings the CPU clock back. The event is an enabled interrupt, or a debug break request. One cycle later the block raises a pulse that starts interrupt stacking, together with a code that picks the vector. A break always picks the software-interrupt vector, and it wins over an interrupt that arrives in the same cycle. A break that arrives while the part sleeps, or in the cycle of the sleep strobe, also sets a sticky status flag. Only reset or a software write of 0 clears that flag.

The watchdog gets its own clock enable. It keeps running in wait mode unless the disable option is set. Reset is asynchronous and outranks every other event.

Top module: `lp_wait_stop_seq`

## Requirements
- R1: While reset is active and after it is released, cpu_clk_en=1, per_clk_en=1, wdog_clk_en=1, imask_clr=0, stack_start=0, vec_sel=2'b00 and brk_flag=0; reset also ends a wait or stop and clears the flag.
- R2: A wait_strobe in run mode with no wake event gives, on the next cycle, cpu_clk_en=0 and per_clk_en=1, with imask_clr high for exactly that one cycle.
- R3: A stop_strobe in run mode, alone or together with wait_strobe, gives cpu_clk_en=0 and per_clk_en=0 and a one-cycle imask_clr pulse on the next cycle.
- R4: In wait mode, any bit of irq_req makes the next cycle show cpu_clk_en=1, stack_start=1 for one cycle and vec_sel=2'b01 (interrupt vector).
- R5: An irq_req in the same cycle as wait_strobe means the part does not sleep: the next cycle has cpu_clk_en=1, imask_clr=1, stack_start=1 and vec_sel=2'b01.
- R6: In stop mode only irq_req bits set in STOP_WAKE_MASK (default 8'h0F) wake the part; other bits leave both clock enables at 0.
- R7: A break_req in any mode gives stack_start=1 and vec_sel=2'b10 (software-interrupt vector) with cpu_clk_en=1 on the next cycle, even when an interrupt arrives in the same cycle.
- R8: A break_req while in wait or stop, or in the cycle of a sleep strobe, sets brk_flag on the next cycle; a break in plain run mode leaves brk_flag unchanged.
- R9: flag_wr with flag_wdata=0 clears brk_flag on the next cycle; flag_wdata=1 has no effect; a set in the same cycle wins over a clear.
- R10: wdog_clk_en is 1 in run mode, equals !wdog_disable in wait mode, and is 0 in stop mode.
- R11: An irq_req in run mode with no sleep strobe produces no stack_start and no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, from any reset source |
| wait_strobe | input | 1 | Decoded WAIT instruction |
| stop_strobe | input | 1 | Decoded STOP instruction |
| irq_req | input | N_IRQ | Enabled interrupt requests |
| break_req | input | 1 | Debug break request |
| wdog_disable | input | 1 | Watchdog disable option |
| flag_wr | input | 1 | Software write strobe for the break status flag |
| flag_wdata | input | 1 | Write data; 0 clears the flag |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wdog_clk_en | output | 1 | Watchdog clock enable |
| imask_clr | output | 1 | One-cycle pulse to clear the interrupt mask |
| stack_start | output | 1 | One-cycle pulse to start interrupt stacking |
| vec_sel | output | 2 | 00 none, 01 interrupt, 10 software-interrupt (break) |
| brk_flag | output | 1 | Sticky flag: a break woke the part from wait or stop |

## Verification
A wrong mode register shows at the clock enables on the cycle right after the strobe or wake event. The enables are decoded straight from that register, so the error is not hidden or delayed. A wrong wake decode shows as a missing or extra stack_start, or a wrong vec_sel code, one cycle after the stimulus. This applies in particular to the stop-mode wake mask and to break priority. A flag error stays visible on brk_flag until reset or a software clear. The bench therefore checks the state after each write, and again after a later break in run mode.

// File: rtl/lp_wait_stop_seq.sv
module lp_wait_stop_seq #(
  parameter int N_IRQ = 8,
  parameter logic [N_IRQ-1:0] STOP_WAKE_MASK = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_strobe,
  input  logic             stop_strobe,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic             break_req,
  input  logic             wdog_disable,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             wdog_clk_en,
  output logic             imask_clr,
  output logic             stack_start,
  output logic [1:0]       vec_sel,
  output logic             brk_flag
);

  typedef enum logic [1:0] {S_RUN, S_WAIT, S_STOP} mode_t;
  localparam logic [1:0] VEC_NONE = 2'b00;
  localparam logic [1:0] VEC_IRQ  = 2'b01;
  localparam logic [1:0] VEC_SWI  = 2'b10;

  mode_t mode_q, mode_d;
  logic  enter_sleep, asleep, stop_ctx, irq_wake, wake;

  assign enter_sleep = (mode_q == S_RUN) && (wait_strobe || stop_strobe);
  assign asleep      = (mode_q != S_RUN) || enter_sleep;
  assign stop_ctx    = (mode_q == S_STOP) || ((mode_q == S_RUN) && stop_strobe);
  assign irq_wake    = stop_ctx ? |(irq_req & STOP_WAKE_MASK) : (asleep && |irq_req);
  assign wake        = irq_wake || break_req;

  always_comb begin
    mode_d = mode_q;
    if (wake)                              mode_d = S_RUN;
    else if (mode_q == S_RUN && stop_strobe) mode_d = S_STOP;
    else if (mode_q == S_RUN && wait_strobe) mode_d = S_WAIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= S_RUN;
      imask_clr   <= 1'b0;
      stack_start <= 1'b0;
      vec_sel     <= VEC_NONE;
      brk_flag    <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      imask_clr   <= enter_sleep;
      stack_start <= wake;
      vec_sel     <= break_req ? VEC_SWI : (irq_wake ? VEC_IRQ : VEC_NONE);
      if (break_req && asleep)         brk_flag <= 1'b1;
      else if (flag_wr && !flag_wdata) brk_flag <= 1'b0;
    end
  end

  assign cpu_clk_en  = (mode_q == S_RUN);
  assign per_clk_en  = (mode_q != S_STOP);
  assign wdog_clk_en = (mode_q == S_RUN) || ((mode_q == S_WAIT) && !wdog_disable);

endmodule

// File: rtl/lp_wait_stop_seq_chk.sv
module lp_wait_stop_seq_chk #(
  parameter int N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IRQ-1:0] irq_req,
  input logic             break_req,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic             wdog_clk_en,
  input logic             imask_clr,
  input logic             stack_start,
  input logic [1:0]       vec_sel,
  input logic             brk_flag
);

  a_r3_stop_gates_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    !per_clk_en |-> !cpu_clk_en);

  a_r10_wdog_off_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !per_clk_en |-> !wdog_clk_en);

  a_r2_imask_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (imask_clr && !cpu_clk_en) |=> !imask_clr);

  a_r4_stack_has_vector: assert property (@(posedge clk) disable iff (!rst_n)
    stack_start |-> (cpu_clk_en && vec_sel != 2'b00));

  a_r4_wait_irq_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && per_clk_en && |irq_req) |=> (cpu_clk_en && stack_start));

  a_r7_break_swi: assert property (@(posedge clk) disable iff (!rst_n)
    break_req |=> (stack_start && vec_sel == 2'b10 && cpu_clk_en));

  a_r8_break_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (break_req && !cpu_clk_en) |=> brk_flag);

  a_r11_run_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !break_req && !imask_clr && !$past(imask_clr) && stack_start) |-> $past(break_req) || $past(!cpu_clk_en) || $past(|irq_req));

endmodule

bind lp_wait_stop_seq lp_wait_stop_seq_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .break_req(break_req),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .wdog_clk_en(wdog_clk_en),
  .imask_clr(imask_clr), .stack_start(stack_start), .vec_sel(vec_sel),
  .brk_flag(brk_flag)
);

// File: tb/sim_lp_wait_stop_seq.sv
module sim_lp_wait_stop_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_strobe = 0, stop_strobe = 0, break_req = 0, wdog_disable = 0;
  logic flag_wr = 0, flag_wdata = 0;
  logic [7:0] irq_req = '0;
  logic cpu_clk_en, per_clk_en, wdog_clk_en, imask_clr, stack_start, brk_flag;
  logic [1:0] vec_sel;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lp_wait_stop_seq u0 (
    .clk(clk), .rst_n(rst_n), .wait_strobe(wait_strobe), .stop_strobe(stop_strobe),
    .irq_req(irq_req), .break_req(break_req), .wdog_disable(wdog_disable),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .wdog_clk_en(wdog_clk_en), .imask_clr(imask_clr),
    .stack_start(stack_start), .vec_sel(vec_sel), .brk_flag(brk_flag)
  );

  // stimulus [21]wait [20]stop [19:12]irq [11]brk [10]wdis [9]wr [8]wdata
  // expected [7]cpu [6]per [5]wdog [4]imask [3]stack [2:1]vec [0]flag
  localparam int NV = 19;
  localparam logic [21:0] VEC [NV] = '{
    22'b0_0_00000000_0_0_0_0_1_1_1_0_0_00_0,
    22'b1_0_00000000_0_0_0_0_0_1_1_1_0_00_0,
    22'b0_0_00000000_0_1_0_0_0_1_0_0_0_00_0,
    22'b0_0_00010000_0_0_0_0_1_1_1_0_1_01_0,
    22'b0_0_00000000_0_0_0_0_1_1_1_0_0_00_0,
    22'b0_0_00000001_0_0_0_0_1_1_1_0_0_00_0,
    22'b1_0_00000010_0_0_0_0_1_1_1_1_1_01_0,
    22'b0_1_00000000_0_0_0_0_0_0_0_1_0_00_0,
    22'b0_0_10000000_0_0_0_0_0_0_0_0_0_00_0,
    22'b0_0_00000100_0_0_0_0_1_1_1_0_1_01_0,
    22'b1_0_00000000_0_0_0_0_0_1_1_1_0_00_0,
    22'b0_0_00000001_1_0_0_0_1_1_1_0_1_10_1,
    22'b0_0_00000000_0_0_1_1_1_1_1_0_0_00_1,
    22'b0_0_00000000_1_0_0_0_1_1_1_0_1_10_1,
    22'b0_0_00000000_0_0_1_0_1_1_1_0_0_00_0,
    22'b0_0_00000000_1_0_0_0_1_1_1_0_1_10_0,
    22'b1_1_00000000_0_0_0_0_0_0_0_1_0_00_0,
    22'b0_0_00000000_1_0_1_0_1_1_1_0_1_10_1,
    22'b0_0_00000000_0_0_1_0_1_1_1_0_0_00_0
  };

  function automatic string req_of(int i);
    case (i)
      0, 4:       return "R1";
      1:          return "R2/R10";
      2:          return "R10";
      3:          return "R4";
      5:          return "R11";
      6:          return "R5";
      7, 16:      return "R3";
      8, 9:       return "R6";
      10:         return "R2";
      11:         return "R7/R8";
      12, 14, 18: return "R9";
      13:         return "R7";
      15:         return "R8";
      default:    return "R9";
    endcase
  endfunction

  function automatic logic [7:0] outs();
    return {cpu_clk_en, per_clk_en, wdog_clk_en, imask_clr, stack_start, vec_sel, brk_flag};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(logic [13:0] s);
    {wait_strobe, stop_strobe, irq_req, break_req, wdog_disable, flag_wr, flag_wdata} = s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1", outs(), 8'b1110_0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", outs(), 8'b1110_0000);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][21:8]);
      @(negedge clk);
      check(req_of(i), outs(), VEC[i][7:0]);
    end
    drive('0);
    // R1: break during wait sets flag, then reset clears it and leaves wait
    wait_strobe = 1; @(negedge clk); wait_strobe = 0;
    break_req = 1;   @(negedge clk); break_req = 0;
    check("R8", outs(), 8'b1110_1101);
    wait_strobe = 1; @(negedge clk); wait_strobe = 0;
    check("R2", outs(), 8'b0111_0001);
    rst_n = 0; #3;
    check("R1", outs(), 8'b1110_0000);
    @(negedge clk); rst_n = 1; @(negedge clk);
    check("R1", outs(), 8'b1110_0000);
    // R6: stop strobe with non-waking irq still sleeps
    stop_strobe = 1; irq_req = 8'h40; @(negedge clk);
    stop_strobe = 0; irq_req = 8'h00;
    check("R6", outs(), 8'b0001_0000);
    irq_req = 8'h08; @(negedge clk); irq_req = 8'h00;
    check("R6", outs(), 8'b1110_1010);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule